// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Core with Interrupt Step

This block is a small processor that runs a program from a single word-addressed memory. That memory holds both code and data as 16-bit words. Each instruction carries a 4-bit operation code in its top bits and a 12-bit direct operand address in its low bits. The core has one accumulator. It can load the accumulator from memory, add a memory word to it, store it to memory, jump, halt, and return from an interrupt handler.

Every instruction passes through a fixed state sequence: fetch, wait for memory, decode, then either an operand read or a store, then execute. The sequence always ends with an interrupt-check step. If the request input is high and interrupts are not masked, that step saves the program counter and accumulator, pulses the acknowledge output for one cycle, and sends the next fetch to a fixed handler address. Interrupts stay masked until the handler executes its return instruction. The return instruction restores the saved program counter and accumulator.

The memory is synchronous. An address presented in one cycle returns its data on the read bus in the next cycle. A write happens at the clock edge when the write enable is high. The system places the program in memory while reset is held, then releases reset. The program counter starts at 0.

Top module: `acc_cpu`

## Requirements
- R1: While the synchronous active-low reset is held, `halted`, `irq_ack` and `mem_we` are 0. After release, the first fetch presents address 0 on `mem_addr`.
- R2: Instructions run in consecutive word order. The program counter advances by one after each fetch. Bits [15:12] of an instruction are the operation code and bits [11:0] are the operand address.
- R3: Operation code 0x1 loads the accumulator with the memory word at the operand address.
- R4: Operation code 0x5 adds the memory word at the operand address to the accumulator. The sum wraps modulo 2^16 and no carry is kept.
- R5: Operation code 0x2 writes the accumulator to the operand address. It is the only instruction that raises `mem_we`, and it does so for exactly one cycle.
- R6: Operation code 0x8 makes the next fetch come from the operand address. The words between the jump and its target are not executed.
- R7: Operation code 0x0 halts the core. `halted` goes to 1 and stays there, with no further memory writes and no interrupt acknowledge, even while `irq` is high.
- R8: If `irq` is high at the interrupt-check step and interrupts are unmasked, `irq_ack` is 1 for exactly one cycle. The next fetch address is 0xFF0.
- R9: Operation code 0xF restores the program counter and accumulator that were saved when the interrupt was taken. Execution then continues at the interrupted point with the interrupted accumulator value.
- R10: From the moment an interrupt is taken until its return instruction executes, a high `irq` is not acknowledged again.
- R11: While `irq` stays low, `irq_ack` never rises and the program runs without leaving its own address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 12 | Word address presented to memory |
| mem_wdata | output | 16 | Data to write (the accumulator) |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_we | output | 1 | Write strobe for the current address |
| irq | input | 1 | Level-sensitive interrupt request |
| irq_ack | output | 1 | One-cycle pulse when an interrupt is taken |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench targets accumulator wraparound at 0xFFFF + 2. A core that kept a 17th bit or saturated would store something other than 0x0001. The interrupt test holds the request high through the whole handler. A core without masking would acknowledge more than once and never reach the handler's store. A core that skipped the context restore would store the handler's loaded value plus the addend instead of the interrupted sum. The jump test places a store between the jump and its target. A core that fell through would write that word. After a halt, the bench raises the request and watches for any write or acknowledge, which would show a core that keeps running.

// File: rtl/acc_cpu_pkg.sv
// Package: shared sizes, operation codes and control-state encoding for the
// accumulator core. Assumes a 16-bit word with a 4-bit code in the top bits.
package acc_cpu_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int OPC_W  = WORD_W - ADDR_W;

    localparam logic [OPC_W-1:0] OPC_HALT  = 4'h0;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 4'h8;
    localparam logic [OPC_W-1:0] OPC_RETI  = 4'hF;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_FWAIT,
        ST_DECODE,
        ST_OPRD,
        ST_OPWAIT,
        ST_EXEC,
        ST_WBACK,
        ST_ICHK,
        ST_HALT
    } cpu_state_t;

    // Per-cycle strobes from the sequencer to the datapath.
    typedef struct packed {
        logic pc_step;
        logic ir_load;
        logic buf_load;
        logic acc_load;
        logic acc_add;
        logic pc_jump;
        logic ctx_save;
        logic ctx_restore;
        logic addr_opnd;
        logic wr_en;
    } cpu_ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
// Accumulator arithmetic: either passes the operand through (load) or adds it
// to the accumulator. Assumes wrap-around arithmetic with no carry out.
module acc_cpu_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd_in,
    input  logic         add_sel,
    output logic [W-1:0] result
);

    // Select load value or modular sum.
    always_comb begin
        if (add_sel) result = acc_in + opnd_in;
        else         result = opnd_in;
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
// Instruction sequencer: walks fetch, wait, decode, operand read or store,
// execute and interrupt check. Owns the interrupt mask.
// Assumes read data is valid one cycle after the address is presented.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int CODE_W = OPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] opcode,
    input  logic              irq,
    output cpu_ctl_t          ctl,
    output logic              irq_ack,
    output logic              halted
);

    cpu_state_t state_q, state_d;
    logic       mask_q;
    logic       take_irq;

    assign take_irq = (state_q == ST_ICHK) && irq && !mask_q;
    assign irq_ack  = take_irq;
    assign halted   = (state_q == ST_HALT);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_FWAIT;
            ST_FWAIT:  state_d = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OPC_HALT:           state_d = ST_HALT;
                    OPC_LOAD, OPC_ADD:  state_d = ST_OPRD;
                    OPC_STORE:          state_d = ST_WBACK;
                    OPC_JUMP, OPC_RETI: state_d = ST_EXEC;
                    default:            state_d = ST_ICHK;
                endcase
            end
            ST_OPRD:   state_d = ST_OPWAIT;
            ST_OPWAIT: state_d = ST_EXEC;
            ST_EXEC:   state_d = ST_ICHK;
            ST_WBACK:  state_d = ST_ICHK;
            ST_ICHK:   state_d = ST_FETCH;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_FETCH;
        endcase
    end

    // Strobe generation per state.
    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_FETCH:  ctl.pc_step  = 1'b1;
            ST_FWAIT:  ctl.ir_load  = 1'b1;
            ST_OPRD:   ctl.addr_opnd = 1'b1;
            ST_OPWAIT: begin
                ctl.addr_opnd = 1'b1;
                ctl.buf_load  = 1'b1;
            end
            ST_EXEC: begin
                ctl.addr_opnd   = 1'b1;
                ctl.acc_load    = (opcode == OPC_LOAD) || (opcode == OPC_ADD);
                ctl.acc_add     = (opcode == OPC_ADD);
                ctl.pc_jump     = (opcode == OPC_JUMP);
                ctl.ctx_restore = (opcode == OPC_RETI);
            end
            ST_WBACK: begin
                ctl.addr_opnd = 1'b1;
                ctl.wr_en     = 1'b1;
            end
            ST_ICHK:   ctl.ctx_save = take_irq;
            default:   ctl = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Interrupt mask: set on entry to the handler, cleared by return.
    always_ff @(posedge clk) begin
        if (!rst_n)               mask_q <= 1'b0;
        else if (take_irq)        mask_q <= 1'b1;
        else if (ctl.ctx_restore) mask_q <= 1'b0;
    end

    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !irq_ack && !ctl.wr_en));

    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    a_r10_mask_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> mask_q);

    a_r5_write_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wr_en |=> !ctl.wr_en);

endmodule

// File: rtl/acc_cpu_dpath.sv
// Datapath: program counter, instruction register, data buffer, accumulator
// and the saved interrupt context. Assumes one strobe set per cycle from the
// sequencer and a fixed handler entry address.
module acc_cpu_dpath
    import acc_cpu_pkg::*;
#(
    parameter int                W        = WORD_W,
    parameter int                AW       = ADDR_W,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 12'hFF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cpu_ctl_t      ctl,
    input  logic [W-1:0]  mem_rdata,
    output logic [W-AW-1:0] opcode,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    output logic          mem_we
);

    localparam int CW = W - AW;

    logic [AW-1:0] pc_q, save_pc_q;
    logic [W-1:0]  ir_q, buf_q, acc_q, save_acc_q;
    logic [W-1:0]  alu_out;
    logic [AW-1:0] opnd_addr;

    assign opnd_addr = ir_q[AW-1:0];
    assign opcode    = ir_q[W-1:AW];
    assign mem_addr  = ctl.addr_opnd ? opnd_addr : pc_q;
    assign mem_wdata = acc_q;
    assign mem_we    = ctl.wr_en;

    acc_cpu_alu #(.W(W)) u_alu (
        .acc_in (acc_q),
        .opnd_in(buf_q),
        .add_sel(ctl.acc_add),
        .result (alu_out)
    );

    // Program counter: step, jump, vector or restore.
    always_ff @(posedge clk) begin
        if (!rst_n)               pc_q <= '0;
        else if (ctl.ctx_save)    pc_q <= VEC_ADDR;
        else if (ctl.ctx_restore) pc_q <= save_pc_q;
        else if (ctl.pc_jump)     pc_q <= opnd_addr;
        else if (ctl.pc_step)     pc_q <= pc_q + 1'b1;
    end

    // Instruction register captures the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n)           ir_q <= '0;
        else if (ctl.ir_load) ir_q <= mem_rdata;
    end

    // Data buffer captures the operand word.
    always_ff @(posedge clk) begin
        if (!rst_n)            buf_q <= '0;
        else if (ctl.buf_load) buf_q <= mem_rdata;
    end

    // Accumulator: loaded from the ALU or restored from the saved context.
    always_ff @(posedge clk) begin
        if (!rst_n)               acc_q <= '0;
        else if (ctl.ctx_restore) acc_q <= save_acc_q;
        else if (ctl.acc_load)    acc_q <= alu_out;
    end

    // Saved context captured when an interrupt is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_pc_q  <= '0;
            save_acc_q <= '0;
        end else if (ctl.ctx_save) begin
            save_pc_q  <= pc_q;
            save_acc_q <= acc_q;
        end
    end

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_step |=> (pc_q == $past(pc_q) + 1'b1));

    a_r9_restore_pc: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ctx_restore |=> (pc_q == $past(save_pc_q) && acc_q == $past(save_acc_q)));

    a_r8_vector_pc: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ctx_save |=> (pc_q == VEC_ADDR));

    a_r6_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_jump |=> (pc_q == $past(opnd_addr)));

    initial assert (CW == 4) else $error("operation code width must be 4");

endmodule

// File: rtl/acc_cpu.sv
// Top of the accumulator core: joins the sequencer and the datapath to a
// synchronous single-port memory. Assumes read latency of one cycle.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'hFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    input  logic              irq,
    output logic              irq_ack,
    output logic              halted
);

    cpu_ctl_t         ctl;
    logic [OPC_W-1:0] opcode;

    acc_cpu_ctrl #(.CODE_W(OPC_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .irq    (irq),
        .ctl    (ctl),
        .irq_ack(irq_ack),
        .halted (halted)
    );

    acc_cpu_dpath #(
        .W       (WORD_W),
        .AW      (ADDR_W),
        .VEC_ADDR(HANDLER_ADDR)
    ) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .mem_rdata(mem_rdata),
        .opcode   (opcode),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_we   (mem_we)
    );

    a_r8_ack_then_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (mem_addr == HANDLER_ADDR && !mem_we));

endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_we;
    logic        irq = 1'b0;
    logic        irq_ack;
    logic        halted;

    logic [15:0] ram [0:4095];

    int n_checks = 0;
    int n_fail   = 0;
    int ack_count = 0;
    int ack_run   = 0;
    int ack_run_max = 0;
    logic        ack_prev = 1'b0;
    logic [11:0] vec_seen = '0;
    int          wr_count = 0;

    always #10 clk = ~clk;

    acc_cpu u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .mem_we   (mem_we),
        .irq      (irq),
        .irq_ack  (irq_ack),
        .halted   (halted)
    );

    // Synchronous memory model with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    // Monitor for acknowledge pulses, vector address and writes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_prev) vec_seen = mem_addr;
            if (irq_ack) begin
                ack_count++;
                ack_run++;
                if (ack_run > ack_run_max) ack_run_max = ack_run;
            end else begin
                ack_run = 0;
            end
            if (mem_we) wr_count++;
            ack_prev = irq_ack;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_ram();
        for (int i = 0; i < 4096; i++) ram[i] = 16'h0000;
    endtask

    task automatic start_core();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        ack_count = 0; ack_run = 0; ack_run_max = 0; ack_prev = 1'b0;
        wr_count = 0; vec_seen = '0;
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string req);
        int cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check(req, halted, 1'b1);
    endtask

    task automatic t_reset();
        clear_ram();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 halted in reset", halted, 1'b0);
        check("R1 ack in reset", irq_ack, 1'b0);
        check("R1 we in reset", mem_we, 1'b0);
        rst_n = 1'b1;
        #1;
        check("R1 first fetch address", mem_addr, 12'h000);
        @(negedge clk);
        check("R2 fetch holds addr before step", mem_addr, 12'h001);
    endtask

    task automatic t_load_add_store();
        clear_ram();
        ram[0] = 16'h1100; ram[1] = 16'h5101; ram[2] = 16'h2102; ram[3] = 16'h0000;
        ram[12'h100] = 16'h1234; ram[12'h101] = 16'h1111;
        start_core();
        wait_halt("R7 halt reached (sum)");
        check("R4 sum stored", ram[12'h102], 16'h2345);
        check("R3 source kept", ram[12'h100], 16'h1234);
        check("R5 single write", wr_count, 1);
        check("R11 no ack with irq low", ack_count, 0);
    endtask

    task automatic t_wrap();
        clear_ram();
        ram[0] = 16'h1100; ram[1] = 16'h5101; ram[2] = 16'h2102; ram[3] = 16'h0000;
        ram[12'h100] = 16'hFFFF; ram[12'h101] = 16'h0002;
        start_core();
        wait_halt("R7 halt reached (wrap)");
        check("R4 wrap sum", ram[12'h102], 16'h0001);
    endtask

    task automatic t_load_store();
        clear_ram();
        ram[0] = 16'h1300; ram[1] = 16'h2301; ram[2] = 16'h2302; ram[3] = 16'h0000;
        ram[12'h300] = 16'hBEEF;
        start_core();
        wait_halt("R7 halt reached (copy)");
        check("R3 load then R5 store a", ram[12'h301], 16'hBEEF);
        check("R5 store b", ram[12'h302], 16'hBEEF);
        check("R5 two writes", wr_count, 2);
    endtask

    task automatic t_jump();
        clear_ram();
        ram[0] = 16'h1100; ram[1] = 16'h8005; ram[2] = 16'h2103;
        ram[3] = 16'h2103; ram[4] = 16'h0000;
        ram[5] = 16'h2104; ram[6] = 16'h0000;
        ram[12'h100] = 16'h00A5;
        start_core();
        wait_halt("R7 halt reached (jump)");
        check("R6 target store", ram[12'h104], 16'h00A5);
        check("R6 skipped store", ram[12'h103], 16'h0000);
    endtask

    task automatic t_halt_sticky();
        logic [11:0] a0;
        clear_ram();
        ram[0] = 16'h0000;
        start_core();
        wait_halt("R7 halt reached (immediate)");
        a0 = mem_addr;
        irq = 1'b1;
        repeat (20) @(negedge clk);
        irq = 1'b0;
        check("R7 still halted", halted, 1'b1);
        check("R7 no write after halt", wr_count, 0);
        check("R7 no ack while halted", ack_count, 0);
        check("R7 address frozen", mem_addr, a0);
    endtask

    task automatic t_interrupt();
        int cyc = 0;
        clear_ram();
        ram[0] = 16'h1100; ram[1] = 16'h5101; ram[2] = 16'h2102; ram[3] = 16'h0000;
        ram[12'h100] = 16'h0010; ram[12'h101] = 16'h0020;
        ram[12'hFF0] = 16'h1200; ram[12'hFF1] = 16'h2201; ram[12'hFF2] = 16'hF000;
        ram[12'h200] = 16'hABCD;
        start_core();
        irq = 1'b1;
        // Hold the request through the handler until its store appears.
        while (!(mem_we && mem_addr == 12'h201) && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        irq = 1'b0;
        wait_halt("R7 halt reached (irq)");
        check("R8 one acknowledge", ack_count, 1);
        check("R8 ack width one cycle", ack_run_max, 1);
        check("R8 vector address", vec_seen, 12'hFF0);
        check("R10 handler ran unmasked-free", ram[12'h201], 16'hABCD);
        check("R9 context restored sum", ram[12'h102], 16'h0030);
    endtask

    initial begin
        t_reset();
        t_load_add_store();
        t_wrap();
        t_load_store();
        t_jump();
        t_halt_sticky();
        t_interrupt();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule